// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block converts a 32-bit virtual address into a physical address by walking translation tables held in memory. A start strobe with a virtual address launches a walk. The walker picks one of two table base values, fetches a first-level descriptor and, when that descriptor points to a second-level table, fetches a second descriptor. It then reports either a physical address or a fault.

Memory is reached through a single read port. The walker raises a request with an address and waits as long as needed for a valid response carrying the data. Only one walk is in flight at a time. Completion is marked by a one-cycle done pulse.

Top module: `xlat_walk`

## Requirements
- R1: A synchronous reset returns the walker to idle; on the cycle after reset is sampled, done, fault and rd_req are all low.
- R2: With split_n equal to 0, the walk always uses tbl_base0. With split_n nonzero, let M be (7 << (32 - split_n)) truncated to 32 bits. A virtual address strictly greater than M uses tbl_base1, and any other address uses tbl_base0. The first read address is (base & 0xFFFFC000) | (va[31:20] << 2).
- R3: Bits [1:0] of the first-level descriptor select its kind. Code 0 ends the walk with a fault after one read. Code 2 is a 1 MB section with pa = {desc[31:20], va[19:0]}.
- R4: First-level code 1 points to a coarse table. The second read address is (desc & 0xFFFFFC00) | (va[19:12] << 2).
- R5: First-level code 3 points to a fine table. The second read address is (desc & 0xFFFFF000) | (va[19:10] << 2).
- R6: Bits [1:0] of the second-level descriptor select the leaf. Code 0 is a fault. Code 1 gives a 64 KB page with pa = {desc[31:16], va[15:0]}. Code 2 gives a 4 KB page with pa = {desc[31:12], va[11:0]}. Code 3 gives a 1 KB page with pa = {desc[31:10], va[9:0]}.
- R7: rd_req stays high with rd_addr unchanged until a cycle in which rd_valid is high. That cycle consumes rd_data. Any number of wait cycles is tolerated, and rd_valid is ignored while rd_req is low.
- R8: done is high for exactly one cycle, in the cycle after the last response is consumed. fault is high only together with done. When done is high and fault is low, pa holds the translation.
- R9: start is ignored while a walk is in progress. It does not alter the running walk and does not launch another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a walk for va when idle |
| va | input | 32 | Virtual address to translate |
| tbl_base0 | input | 32 | Base of the lower table |
| tbl_base1 | input | 32 | Base of the upper table |
| split_n | input | 3 | Split field that enables and places the upper table |
| rd_req | output | 1 | Memory read request, held until answered |
| rd_addr | output | 32 | Memory read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation fault, qualified by done |
| pa | output | 32 | Physical address result |

## Verification
A wrong state encoding or a bad latched address shows up first as a wrong rd_addr on the very first or second request. The bench compares that address against its own computation before the walk completes. A wrong descriptor decode shows up one cycle after the final response, as a wrong pa, a wrong fault, or an unexpected extra read. The sweep covers every split value, the addresses on either side of each split boundary, every descriptor code at both levels, and several response latencies, so any such error appears within a few walks.

// File: rtl/xlat_walk.sv
module xlat_walk (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] va,
  input  logic [31:0] tbl_base0,
  input  logic [31:0] tbl_base1,
  input  logic [2:0]  split_n,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_valid,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic        fault,
  output logic [31:0] pa
);
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;

  st_t         st;
  logic [31:0] va_q;
  logic [63:0] split_wide;
  logic [31:0] split_mask;
  logic        use_hi;
  logic [31:0] base_sel;
  logic [31:0] l1_addr;

  assign split_wide = 64'd7 << (6'd32 - {3'd0, split_n});
  assign split_mask = split_wide[31:0];
  assign use_hi     = (split_n != 3'd0) && (va > split_mask);
  assign base_sel   = use_hi ? tbl_base1 : tbl_base0;
  assign l1_addr    = {base_sel[31:14], va[31:20], 2'b00};
  assign rd_req     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      va_q    <= '0;
      rd_addr <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
      pa      <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q    <= va;
          rd_addr <= l1_addr;
          st      <= S_L1;
        end
        S_L1: if (rd_valid) begin
          case (rd_data[1:0])
            2'd0: begin
              fault <= 1'b1; done <= 1'b1; pa <= '0; st <= S_IDLE;
            end
            2'd2: begin
              pa <= {rd_data[31:20], va_q[19:0]}; done <= 1'b1; st <= S_IDLE;
            end
            2'd1: begin
              rd_addr <= {rd_data[31:10], va_q[19:12], 2'b00}; st <= S_L2;
            end
            default: begin
              rd_addr <= {rd_data[31:12], va_q[19:10], 2'b00}; st <= S_L2;
            end
          endcase
        end
        S_L2: if (rd_valid) begin
          done <= 1'b1;
          st   <= S_IDLE;
          case (rd_data[1:0])
            2'd0:    begin fault <= 1'b1; pa <= '0; end
            2'd1:    pa <= {rd_data[31:16], va_q[15:0]};
            2'd2:    pa <= {rd_data[31:12], va_q[11:0]};
            default: pa <= {rd_data[31:10], va_q[9:0]};
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!done && !fault && !rd_req));

  p_zero_code_faults_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid && rd_data[1:0] == 2'd0) |=> (done && fault));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fault_qual_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid && start) |=> $stable(rd_addr));
endmodule

// File: tb/sim_xlat_walk.sv
`timescale 1ns/1ps
module sim_xlat_walk;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic [31:0] tbl_base0 = 32'h1234_5FFF;
  logic [31:0] tbl_base1 = 32'hABCD_E123;
  logic [2:0]  split_n = '0;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done, fault;
  logic [31:0] pa;

  int checks = 0;
  int fails = 0;
  logic [31:0] l1_desc = '0, l2_desc = '0;
  logic [31:0] seen_a [0:3];
  int nreads = 0, wcnt = 0, lat = 0;
  bit spurious = 1'b0;

  xlat_walk u0 (.clk(clk), .rst(rst), .start(start), .va(va),
    .tbl_base0(tbl_base0), .tbl_base1(tbl_base1), .split_n(split_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .fault(fault), .pa(pa));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      rd_valid = 1'b0; wcnt = 0;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        rd_valid = 1'b1;
        if (nreads < 4) seen_a[nreads] = rd_addr;
        rd_data = (nreads == 0) ? l1_desc : l2_desc;
        nreads++;
        wcnt = 0;
      end else begin
        rd_valid = 1'b0; rd_data = 32'hFFFF_FFFF; wcnt++;
      end
    end else begin
      rd_valid = spurious; rd_data = 32'hFFFF_FFFE; wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] v, input logic [2:0] n, input logic [1:0] t1,
                      input logic [1:0] t2, input int l, input bit intf);
    logic [63:0] w;
    logic [31:0] m, eb, el1, el2, d1, d2, epa;
    bit efault;
    int en, cyc;
    w = 64'd7 << (32 - n);
    m = w[31:0];
    eb = ((n != 0) && (v > m)) ? tbl_base1 : tbl_base0;
    el1 = (eb & 32'hFFFF_C000) | {18'd0, v[31:20], 2'b00};
    d1 = 32'h8765_4FF0 | {30'd0, t1};
    d2 = 32'h3C3C_3FFC | {30'd0, t2};
    efault = 1'b0; epa = '0; el2 = '0; en = 1;
    case (t1)
      2'd0: efault = 1'b1;
      2'd2: epa = (d1 & 32'hFFF0_0000) + (v & 32'h000F_FFFF);
      2'd1: begin en = 2; el2 = (d1 & 32'hFFFF_FC00) | ({24'd0, v[19:12]} * 4); end
      default: begin en = 2; el2 = (d1 & 32'hFFFF_F000) | ({22'd0, v[19:10]} * 4); end
    endcase
    if (en == 2) begin
      case (t2)
        2'd0: efault = 1'b1;
        2'd1: epa = (d2 & 32'hFFFF_0000) + (v & 32'h0000_FFFF);
        2'd2: epa = (d2 & 32'hFFFF_F000) + (v & 32'h0000_0FFF);
        default: epa = (d2 & 32'hFFFF_FC00) + (v & 32'h0000_03FF);
      endcase
    end
    l1_desc = d1; l2_desc = d2; lat = l; nreads = 0; spurious = intf;
    split_n = n; va = v; start = 1'b1;
    @(negedge clk);
    start = intf; va = ~v; split_n = ~n;
    cyc = 0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    start = 1'b0;
    chk(done, "R8 done seen", {31'd0, done}, 32'd1);
    chk(fault == efault, "R3/R6 fault", {31'd0, fault}, {31'd0, efault});
    if (!efault) chk(pa == epa, (en == 1) ? "R3 section pa" : "R6 leaf pa", pa, epa);
    chk(seen_a[0] == el1, "R2 first read address", seen_a[0], el1);
    if (en == 2) chk(seen_a[1] == el2, (t1 == 2'd1) ? "R4 coarse address" : "R5 fine address", seen_a[1], el2);
    chk(nreads == en, "R7 read count", nreads, en);
    @(negedge clk);
    chk(!done && !fault, "R8 done single cycle", {30'd0, done, fault}, 32'd0);
    chk(!rd_req && nreads == en, "R9 no walk from busy start", {31'd0, rd_req}, 32'd0);
    spurious = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] vl [0:4];
    logic [63:0] w;
    logic [31:0] m;
    int idx;
    repeat (3) @(negedge clk);
    chk(!done && !fault && !rd_req, "R1 reset state", {29'd0, done, fault, rd_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req && !done, "R1 idle after reset", {31'd0, rd_req}, 32'd0);

    // mid-walk reset
    l1_desc = 32'h0000_0001; lat = 6; nreads = 0; va = 32'h0040_0000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(rd_req, "R7 request during wait", {31'd0, rd_req}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(!done && !fault && !rd_req, "R1 reset mid-walk", {29'd0, done, fault, rd_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    idx = 0;
    for (int n = 0; n < 8; n++) begin
      w = 64'd7 << (32 - n);
      m = w[31:0];
      vl[0] = m; vl[1] = m + 1; vl[2] = 32'h0; vl[3] = 32'hFFFF_FFFF;
      vl[4] = 32'h5A3C_96E1 ^ (n * 32'h0110_2203);
      for (int k = 0; k < 5; k++) begin
        for (int t1 = 0; t1 < 4; t1++) begin
          for (int t2 = 0; t2 < 4; t2++) begin
            if ((t1 % 2 == 0) && t2 != 0) continue;
            walk(vl[k], n[2:0], t1[1:0], t2[1:0], idx % 3, idx[0]);
            idx++;
          end
        end
      end
    end
    walk(32'hC030_1234, 3'd2, 2'd3, 2'd3, 9, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule